// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt events from a fixed number of peripheral sources and turns them into one vectored request for a processor core. Every source has three controls: an enable bit, a pending flag and a three-bit priority level. An event sets the pending flag whether or not the source is enabled. Among the sources that are enabled and pending, the one with the highest level is chosen. On equal levels, the lower source index wins. The chosen request goes to the core only when its level is strictly above the core's current execution level.

The controller then presents a vector address and the accepted level, and holds both until the core acknowledges. The vector address is a table base plus the source index times the vector stride. One global select bit switches every lookup from the main table base to the alternate table base. The core raises its execution level to the reported level on entry and restores the old level on return. This is what lets a higher-level request preempt a handler already in service. Software reaches enables, flags, levels and the table-select bit through a small register port. Flags are cleared only by writing ones to them.

Delivery is a three-state machine:
- IDLE goes to OFFER when an eligible request exists. It captures the vector and level on that clock edge.
- OFFER holds the request and goes to SETTLE when acknowledged.
- SETTLE lasts one cycle, so the core can update its level, then returns to IDLE.

Register map (word addresses on `reg_addr`):
- Address 0 holds the enable bits, bit i for source i.
- Address 1 holds the pending flags. A read returns them. A write clears every flag whose data bit is 1.
- Address 2 holds the alternate-table select in bit 0.
- Addresses 4+i hold the level of source i in bits 2:0.

Top module: `irq_vec_ctl`

## Requirements
- R1: After reset, all enables, flags, levels and the table-select bit read as zero, and `irq_req` is low.
- R2: An event on `irq_evt[i]` sets flag i, visible at address 1 in the next cycle, even while source i is disabled. A disabled source raises no request; once it is enabled, its latched request is delivered.
- R3: Acknowledging a vector does not clear the flag. Writing 1 to a flag bit at address 1 clears it, and writing 0 leaves it. A flag that is left set raises its request again once the core level drops below its level.
- R4: If a clearing write and a new event hit the same source in the same cycle, the flag stays set.
- R5: Among eligible sources the highest level wins. `irq_vec` = base + index*4 with the defaults main base 0x0100 and alternate base 0x0800, and `irq_lvl` equals the winner's level.
- R6: On equal levels the lower source index wins.
- R7: With bit 0 of address 2 set, every vector uses the alternate base and none uses the main base.
- R8: A source is forwarded only if its level is strictly greater than `cpu_level`, so level 0 never requests.
- R9: While `irq_req` is high and unacknowledged, `irq_vec` and `irq_lvl` stay unchanged, even if the table select or the flags change.
- R10: The cycle after an acknowledge, `irq_req` is low (SETTLE). A request whose level exceeds the raised core level is then delivered, which gives nested preemption.
- R11: `irq_req` rises in the second cycle after the event cycle: the flag is set on the first edge, and OFFER is entered on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_evt | input | NUM_SRC | Per-source event pulses |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register word address |
| reg_wdata | input | NUM_SRC | Register write data |
| reg_rdata | output | NUM_SRC | Register read data (combinational) |
| cpu_level | input | 3 | Core's current execution level |
| irq_req | output | 1 | Vectored request valid |
| irq_vec | output | ADDR_W | Vector address |
| irq_lvl | output | 3 | Level of the offered request |
| irq_ack | input | 1 | Core acknowledge of the offered vector |

## Verification
The bench targets these corner cases, one at a time:
- **Tie between equal levels.** A design that swapped the tie-break would vector to the higher index.
- **Event on a masked source.** A design that gated the flag with the enable would lose the event for good.
- **Clearing write landing with a new event.** A design that let the clear win would drop that event.
- **Flag after acknowledge.** A design that cleared it on acknowledge would never re-raise an unserviced request.
- **Source level equal to the core level.** A design with a non-strict comparison would deliver it.
- **Table select toggled while a vector is held.** A design that recomputed the vector would change its output before the acknowledge.
- **Nested preemption after the settle cycle.** A design without the SETTLE gap could re-offer the source just acknowledged before the core raised its level.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
    localparam int PRIO_W   = 3;
    localparam int OFS_EN   = 0;
    localparam int OFS_PEND = 1;
    localparam int OFS_CTRL = 2;
    localparam int OFS_PRIO = 4;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_OFFER  = 2'd1,
        ST_SETTLE = 2'd2
    } dlv_state_e;
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
    import irq_vec_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int AW      = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC-1:0]        evt,
    input  logic                      we,
    input  logic [AW-1:0]             addr,
    input  logic [NUM_SRC-1:0]        wdata,
    output logic [NUM_SRC-1:0]        en_q,
    output logic [NUM_SRC-1:0]        pend_q,
    output logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    output logic                      alt_q,
    output logic [NUM_SRC-1:0]        rdata
);
    logic wr_en_reg;
    logic wr_pend_reg;
    logic wr_ctrl_reg;

    assign wr_en_reg   = we && (addr == AW'(OFS_EN));
    assign wr_pend_reg = we && (addr == AW'(OFS_PEND));
    assign wr_ctrl_reg = we && (addr == AW'(OFS_CTRL));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            alt_q <= 1'b0;
        end else begin
            if (wr_en_reg)   en_q  <= wdata;
            if (wr_ctrl_reg) alt_q <= wdata[0];
        end
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic clr_hit;
        logic wr_prio;

        assign clr_hit = wr_pend_reg && wdata[i];
        assign wr_prio = we && (addr == AW'(OFS_PRIO + i));

        // a new event always wins over a clear in the same cycle
        always_ff @(posedge clk) begin
            if (!rst_n) pend_q[i] <= 1'b0;
            else        pend_q[i] <= (pend_q[i] & ~clr_hit) | evt[i];
        end

        always_ff @(posedge clk) begin
            if (!rst_n)       prio_flat[i*PRIO_W +: PRIO_W] <= '0;
            else if (wr_prio) prio_flat[i*PRIO_W +: PRIO_W] <= wdata[PRIO_W-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == AW'(OFS_EN))   rdata = en_q;
        if (addr == AW'(OFS_PEND)) rdata = pend_q;
        if (addr == AW'(OFS_CTRL)) rdata = NUM_SRC'(alt_q);
        for (int k = 0; k < NUM_SRC; k++) begin
            if (addr == AW'(OFS_PRIO + k))
                rdata = NUM_SRC'(prio_flat[k*PRIO_W +: PRIO_W]);
        end
    end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_vec_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int IW      = 3
) (
    input  logic [NUM_SRC-1:0]        en,
    input  logic [NUM_SRC-1:0]        pend,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    input  logic [PRIO_W-1:0]         cpu_level,
    output logic                      hit,
    output logic [IW-1:0]             idx,
    output logic [PRIO_W-1:0]         lvl
);
    // strict comparison keeps the lowest index on a tie
    always_comb begin
        hit = 1'b0;
        idx = '0;
        lvl = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (en[i] && pend[i]
                && (prio_flat[i*PRIO_W +: PRIO_W] > cpu_level)
                && (prio_flat[i*PRIO_W +: PRIO_W] > lvl)) begin
                hit = 1'b1;
                idx = IW'(i);
                lvl = prio_flat[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/irq_deliver.sv
module irq_deliver
    import irq_vec_pkg::*;
#(
    parameter int          IW         = 3,
    parameter int          ADDR_W     = 16,
    parameter int          VEC_STRIDE = 4,
    parameter logic [15:0] MAIN_BASE  = 16'h0100,
    parameter logic [15:0] ALT_BASE   = 16'h0800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic [IW-1:0]     idx,
    input  logic [PRIO_W-1:0] lvl,
    input  logic              alt,
    input  logic              ack,
    output logic              req,
    output logic [ADDR_W-1:0] vec,
    output logic [PRIO_W-1:0] out_lvl
);
    dlv_state_e state_q, state_n;
    logic [ADDR_W-1:0] base_sel;

    assign base_sel = alt ? ADDR_W'(ALT_BASE) : ADDR_W'(MAIN_BASE);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:   if (hit) state_n = ST_OFFER;
            ST_OFFER:  if (ack) state_n = ST_SETTLE;
            ST_SETTLE: state_n = ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec     <= '0;
            out_lvl <= '0;
        end else if (state_q == ST_IDLE && hit) begin
            vec     <= base_sel + ADDR_W'(idx) * ADDR_W'(VEC_STRIDE);
            out_lvl <= lvl;
        end
    end

    always_comb begin
        req = (state_q == ST_OFFER);
    end
endmodule

// File: rtl/irq_vec_ctl.sv
module irq_vec_ctl
    import irq_vec_pkg::*;
#(
    parameter int          NUM_SRC    = 8,
    parameter int          ADDR_W     = 16,
    parameter int          VEC_STRIDE = 4,
    parameter logic [15:0] MAIN_BASE  = 16'h0100,
    parameter logic [15:0] ALT_BASE   = 16'h0800,
    localparam int         REG_AW     = $clog2(OFS_PRIO + NUM_SRC),
    localparam int         IW         = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_evt,
    input  logic               reg_we,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic [NUM_SRC-1:0] reg_wdata,
    output logic [NUM_SRC-1:0] reg_rdata,
    input  logic [PRIO_W-1:0]  cpu_level,
    output logic               irq_req,
    output logic [ADDR_W-1:0]  irq_vec,
    output logic [PRIO_W-1:0]  irq_lvl,
    input  logic               irq_ack
);
    logic [NUM_SRC-1:0]        en_q;
    logic [NUM_SRC-1:0]        pend_q;
    logic [NUM_SRC*PRIO_W-1:0] prio_flat;
    logic                      alt_q;
    logic                      cand_hit;
    logic [IW-1:0]             cand_idx;
    logic [PRIO_W-1:0]         cand_lvl;

    irq_src_bank #(.NUM_SRC(NUM_SRC), .AW(REG_AW)) bank_i (
        .clk(clk), .rst_n(rst_n), .evt(irq_evt), .we(reg_we),
        .addr(reg_addr), .wdata(reg_wdata), .en_q(en_q), .pend_q(pend_q),
        .prio_flat(prio_flat), .alt_q(alt_q), .rdata(reg_rdata)
    );

    irq_pick #(.NUM_SRC(NUM_SRC), .IW(IW)) pick_i (
        .en(en_q), .pend(pend_q), .prio_flat(prio_flat),
        .cpu_level(cpu_level), .hit(cand_hit), .idx(cand_idx), .lvl(cand_lvl)
    );

    irq_deliver #(
        .IW(IW), .ADDR_W(ADDR_W), .VEC_STRIDE(VEC_STRIDE),
        .MAIN_BASE(MAIN_BASE), .ALT_BASE(ALT_BASE)
    ) dlv_i (
        .clk(clk), .rst_n(rst_n), .hit(cand_hit), .idx(cand_idx),
        .lvl(cand_lvl), .alt(alt_q), .ack(irq_ack), .req(irq_req),
        .vec(irq_vec), .out_lvl(irq_lvl)
    );
endmodule

// File: rtl/irq_vec_ctl_chk.sv
module irq_vec_ctl_chk #(
    parameter int NUM_SRC = 8,
    parameter int ADDR_W  = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] irq_evt,
    input logic [NUM_SRC-1:0] pend,
    input logic [2:0]         cpu_level,
    input logic               irq_req,
    input logic               irq_ack,
    input logic [ADDR_W-1:0]  irq_vec,
    input logic [2:0]         irq_lvl
);
    // R2 R4
    evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_evt != '0) |=> ((pend & $past(irq_evt)) == $past(irq_evt)));

    // R9
    offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_ack) |=> (irq_req && $stable(irq_vec) && $stable(irq_lvl)));

    // R10
    settle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack) |=> !irq_req);

    // R8
    above_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> (irq_lvl > $past(cpu_level)));

    // R8
    nonzero_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_lvl != 3'd0));
endmodule

bind irq_vec_ctl irq_vec_ctl_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .irq_evt(irq_evt), .pend(pend_q),
    .cpu_level(cpu_level), .irq_req(irq_req), .irq_ack(irq_ack),
    .irq_vec(irq_vec), .irq_lvl(irq_lvl)
);

// File: tb/irq_vec_ctl_tb_top.sv
module irq_vec_ctl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_evt = '0;
    logic       reg_we = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [2:0] cpu_level = '0;
    logic       irq_req;
    logic [15:0] irq_vec;
    logic [2:0] irq_lvl;
    logic       irq_ack = 1'b0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_vec_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .irq_evt(irq_evt), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cpu_level(cpu_level), .irq_req(irq_req), .irq_vec(irq_vec),
        .irq_lvl(irq_lvl), .irq_ack(irq_ack)
    );

    // {en[60:53], prio[52:29], evt[28:21], alt[20], lvl[19:17], req[16], vec[15:0]}
    localparam int NV = 10;
    localparam logic [60:0] TBL [NV] = '{
        {8'hFF, 24'd5 << 9,                      8'h08, 1'b0, 3'd0, 1'b1, 16'h010C},
        {8'hFF, (24'd2 << 3) | (24'd6 << 15),    8'h22, 1'b0, 3'd0, 1'b1, 16'h0114},
        {8'hFF, (24'd4 << 6) | (24'd4 << 18),    8'h44, 1'b0, 3'd0, 1'b1, 16'h0108},
        {8'hFF, (24'd4 << 6) | (24'd4 << 18),    8'h44, 1'b1, 3'd0, 1'b1, 16'h0808},
        {8'hFF, 24'd3 << 12,                     8'h10, 1'b0, 3'd3, 1'b0, 16'h0000},
        {8'hFF, 24'd4 << 12,                     8'h10, 1'b0, 3'd3, 1'b1, 16'h0110},
        {8'hFE, 24'd7,                           8'h01, 1'b0, 3'd0, 1'b0, 16'h0000},
        {8'hFF, 24'd0,                           8'h80, 1'b0, 3'd0, 1'b0, 16'h0000},
        {8'hFF, 24'd1 | (24'd2 << 21),           8'h81, 1'b0, 3'd0, 1'b1, 16'h011C},
        {8'hFF, 24'd7 | (24'd7 << 21),           8'h81, 1'b1, 3'd0, 1'b1, 16'h0800}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; irq_evt = '0; reg_we = 1'b0; irq_ack = 1'b0; cpu_level = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [7:0] e);
        @(negedge clk);
        irq_evt = e;
        @(negedge clk);
        irq_evt = '0;
    endtask

    task automatic ack_now();
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;

        // table walk: R5 R6 R7 R8 R2
        for (int n = 0; n < NV; n++) begin
            do_reset();
            for (int k = 0; k < 8; k++)
                wr(4'(4 + k), {5'd0, TBL[n][29 + 3*k +: 3]});
            wr(4'd2, {7'd0, TBL[n][20]});
            wr(4'd0, TBL[n][60:53]);
            cpu_level = TBL[n][19:17];
            pulse(TBL[n][28:21]);
            @(negedge clk);
            @(negedge clk);
            chk($sformatf("R5/R6/R7/R8 table %0d req", n), 32'(irq_req), 32'(TBL[n][16]));
            if (TBL[n][16])
                chk($sformatf("R5/R6/R7 table %0d vec", n), 32'(irq_vec), 32'(TBL[n][15:0]));
        end

        // R1 reset state
        do_reset();
        rd(4'd0, d); chk("R1 enable reset", 32'(d), 0);
        rd(4'd1, d); chk("R1 flag reset", 32'(d), 0);
        rd(4'd2, d); chk("R1 select reset", 32'(d), 0);
        rd(4'd7, d); chk("R1 level reset", 32'(d), 0);
        chk("R1 req reset", 32'(irq_req), 0);

        // R2 masked event latched, delivered after enable
        wr(4'd7, 8'd5);
        wr(4'd5, 8'd7);
        pulse(8'h08);
        @(negedge clk);
        rd(4'd1, d); chk("R2 flag while masked", 32'(d), 32'h08);
        chk("R2 no req while masked", 32'(irq_req), 0);
        wr(4'd0, 8'h0A);
        @(negedge clk);
        chk("R2 req after enable", 32'(irq_req), 1);
        chk("R5 vec src3", 32'(irq_vec), 32'h010C);
        chk("R5 lvl src3", 32'(irq_lvl), 5);

        // R9 hold while select toggles
        wr(4'd2, 8'h01);
        @(negedge clk);
        chk("R9 req held", 32'(irq_req), 1);
        chk("R9 vec held", 32'(irq_vec), 32'h010C);
        wr(4'd2, 8'h00);

        // R10 settle, R3 flag survives acknowledge
        ack_now();
        cpu_level = 3'd5;
        chk("R10 settle low", 32'(irq_req), 0);
        rd(4'd1, d); chk("R3 flag after ack", 32'(d), 32'h08);

        // R10 nesting: src1 level 7 over core level 5
        pulse(8'h02);
        @(negedge clk);
        @(negedge clk);
        chk("R10 nested req", 32'(irq_req), 1);
        chk("R10 nested vec", 32'(irq_vec), 32'h0104);
        chk("R10 nested lvl", 32'(irq_lvl), 7);
        ack_now();
        cpu_level = 3'd7;

        // R3 write-one-to-clear
        wr(4'd1, 8'h00);
        rd(4'd1, d); chk("R3 zero write keeps", 32'(d), 32'h0A);
        wr(4'd1, 8'h02);
        rd(4'd1, d); chk("R3 one write clears", 32'(d), 32'h08);

        // R3 uncleared flag re-requests after return
        cpu_level = 3'd0;
        @(negedge clk); @(negedge clk); @(negedge clk);
        chk("R3 re-request", 32'(irq_req), 1);
        chk("R3 re-request vec", 32'(irq_vec), 32'h010C);

        // R4 clear and event collide
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 4'd1; reg_wdata = 8'h08; irq_evt = 8'h08;
        @(negedge clk);
        reg_we = 1'b0; irq_evt = '0;
        rd(4'd1, d); chk("R4 collide keeps flag", 32'(d), 32'h08);
        wr(4'd1, 8'h08);
        rd(4'd1, d); chk("R3 clear src3", 32'(d), 0);
        ack_now();
        @(negedge clk); @(negedge clk);
        chk("R3 no req after clear", 32'(irq_req), 0);

        // R11 request timing
        pulse(8'h08);
        chk("R11 req low one cycle after event", 32'(irq_req), 0);
        @(negedge clk);
        chk("R11 req high two cycles after event", 32'(irq_req), 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule